// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer N and emits one pulse per N input cycles. That pulse is the feedback-side comparison event for a phase detector in a frequency synthesizer. The division is not done by one wide binary counter. A two-modulus prescaler divides by 33 or by 32. A small swallow counter decides how many prescaler periods use the longer modulus, and a main counter sets how many prescaler periods make up one full output cycle. The result is N = 32·M + S, where S is the swallow value and M is the main value.

Everything is synchronous to the divided input clock. A load strobe copies new S and M values into holding registers at any time, including while the block is in standby. The counters take the held values only at the boundary between two output cycles, so a reprogramming never cuts an output period short. An active-low run control puts the block into standby: the counters are held at their start state and the output stays low. When run is restored, counting starts a fresh cycle.

Top module: `pswl_divider`

## Requirements
- R1: While rst_n is low, fv_pulse is 0 and the held values reset to S = 0, M = 32. If run_en is high from the release of reset with no load, the first fv_pulse arrives on the 1024th rising edge.
- R2: After values S and M are loaded in standby and run_en rises, fv_pulse is first high after the N-th rising clock edge at which run_en is high, with N = 32·M + S.
- R3: While running with unchanged values, consecutive fv_pulse assertions are exactly N input cycles apart.
- R4: fv_pulse is high for exactly one input clock cycle per output period.
- R5: Within each output cycle, the first S prescaler periods last 33 input cycles and the remaining M − S periods last 32. With M = 32, S = 31 gives a period 31 cycles longer than S = 0.
- R6: While run_en is low, fv_pulse stays 0 and all counters return to their start state. After run_en rises again, the first pulse arrives N cycles later, and progress made before standby does not count.
- R7: A load_stb pulse during a running cycle does not change the length of that cycle. The loaded values define the length of the following cycle.
- R8: The extreme setting S = 31, M = 2047 gives N = 65535 with no counter overflow. Valid settings are S in 0..31 and M in 32..2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High to run, low for standby |
| load_stb | input | 1 | Captures swallow_val and main_val into the holding registers on a rising edge |
| swallow_val | input | 5 | Swallow value S (0..31) |
| main_val | input | 11 | Main value M (32..2047) |
| fv_pulse | output | 1 | One-cycle divided output pulse |

## Verification
Every internal fault in this divider shows up as a wrong distance between fv_pulse events. A prescaler modulus chosen for the wrong periods shifts the period by up to 31 cycles. A main counter that is off by one shifts it by 32. A reload taken mid-cycle shortens the period that is running when the load arrives. All of these become visible at the first pulse after the fault, at most N input cycles later. A standby that fails to clear the counters shows up as a first pulse that comes early after run_en is restored.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  // default field widths; prescaler base modulus is 2**DEF_SW_W
  localparam int DEF_SW_W = 5;
  localparam int DEF_MN_W = 11;

  // modulus selector for the two-modulus prescaler
  typedef enum logic {
    MOD_BASE = 1'b0,   // divide by 2**SW_W
    MOD_PLUS = 1'b1    // divide by 2**SW_W + 1
  } pswl_mod_e;

  // divide ratio for a given setting, generic over widths via concatenation:
  // {m, s} equals m * 2**SW_W + s
  function automatic int unsigned pswl_ratio(input int unsigned s, input int unsigned m,
                                             input int unsigned sw_w);
    return (m << sw_w) + s;
  endfunction
endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
  import pswl_pkg::*;
#(
  parameter int PW = DEF_SW_W
) (
  input  logic      clk_in,
  input  logic      rst_n,
  input  logic      hold,
  input  pswl_mod_e modsel,
  output logic      wrap
);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] LAST_BASE = CW'((2 ** PW) - 1);
  localparam logic [CW-1:0] LAST_PLUS = CW'(2 ** PW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_val;

  assign last_val = (modsel == MOD_PLUS) ? LAST_PLUS : LAST_BASE;
  assign wrap     = !hold && (cnt == last_val);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pswl_swallow_ctr.sv
module pswl_swallow_ctr #(
  parameter int SW_W = 5
) (
  input  logic            clk_in,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [SW_W-1:0] reload_val,
  input  logic            step,
  output logic            active
);
  logic [SW_W-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= reload_val;
    end else if (step && active) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pswl_main_ctr.sv
module pswl_main_ctr #(
  parameter int MN_W = 11,
  parameter logic [MN_W-1:0] RST_VAL = MN_W'(32)
) (
  input  logic            clk_in,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [MN_W-1:0] reload_val,
  input  logic            step,
  output logic            last
);
  localparam logic [MN_W-1:0] ONE = MN_W'(1);

  logic [MN_W-1:0] cnt;

  assign last = (cnt == ONE);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RST_VAL;
    end else if (reload) begin
      cnt <= reload_val;
    end else if (step) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider
  import pswl_pkg::*;
#(
  parameter int SW_W = DEF_SW_W,
  parameter int MN_W = DEF_MN_W
) (
  input  logic            clk_in,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            load_stb,
  input  logic [SW_W-1:0] swallow_val,
  input  logic [MN_W-1:0] main_val,
  output logic            fv_pulse
);
  localparam int PRE_MOD = 2 ** SW_W;
  localparam logic [MN_W-1:0] MAIN_RST = MN_W'(PRE_MOD);

  // held settings
  logic [SW_W-1:0] pend_s;
  logic [MN_W-1:0] pend_m;

  // named internal events
  logic      pre_wrap;
  logic      sw_active;
  logic      main_last;
  logic      cycle_end;
  logic      restart;
  logic      period_step;
  pswl_mod_e pre_mod;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pend_s <= '0;
      pend_m <= MAIN_RST;
    end else if (load_stb) begin
      pend_s <= swallow_val;
      pend_m <= main_val;
    end
  end

  assign pre_mod     = sw_active ? MOD_PLUS : MOD_BASE;
  assign cycle_end   = run_en && pre_wrap && main_last;
  assign restart     = !run_en || cycle_end;
  assign period_step = run_en && pre_wrap;

  pswl_prescaler #(.PW(SW_W)) u_pre (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .hold   (!run_en),
    .modsel (pre_mod),
    .wrap   (pre_wrap)
  );

  pswl_swallow_ctr #(.SW_W(SW_W)) u_sw (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .reload     (restart),
    .reload_val (pend_s),
    .step       (period_step),
    .active     (sw_active)
  );

  pswl_main_ctr #(.MN_W(MN_W), .RST_VAL(MAIN_RST)) u_main (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .reload     (restart),
    .reload_val (pend_m),
    .step       (period_step),
    .last       (main_last)
  );

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      fv_pulse <= 1'b0;
    end else begin
      fv_pulse <= cycle_end;
    end
  end
endmodule

// File: rtl/pswl_divider_chk.sv
module pswl_divider_chk #(
  parameter int SW_W = 5,
  parameter int MN_W = 11
) (
  input logic            clk_in,
  input logic            rst_n,
  input logic            run_en,
  input logic            fv_pulse,
  input logic            cycle_end,
  input logic            pre_wrap,
  input logic            sw_active,
  input logic            main_last,
  input logic [SW_W-1:0] pend_s,
  input logic [MN_W-1:0] pend_m
);
  localparam int NW = SW_W + MN_W;
  localparam logic [NW:0] RST_N = (NW+1)'(2 ** (2 * SW_W));

  logic [NW:0] run_cnt;
  logic [NW:0] exp_n;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      exp_n   <= RST_N;
    end else if (!run_en || cycle_end) begin
      run_cnt <= '0;
      exp_n   <= {1'b0, pend_m, pend_s};
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2
  period_match_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    run_en |-> (cycle_end == (run_cnt == exp_n - 1'b1)));

  // R4
  pulse_width_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    fv_pulse |=> !fv_pulse);

  // R6
  standby_quiet_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !run_en |=> !fv_pulse);

  // R5
  swallow_first_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_en && main_last) |-> !sw_active);

  // R5
  swallow_step_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (run_en && $past(run_en) && !$past(cycle_end) && $fell(sw_active)) |-> $past(pre_wrap));
endmodule

bind pswl_divider pswl_divider_chk #(.SW_W(SW_W), .MN_W(MN_W)) u_chk (
  .clk_in    (clk_in),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .fv_pulse  (fv_pulse),
  .cycle_end (cycle_end),
  .pre_wrap  (pre_wrap),
  .sw_active (sw_active),
  .main_last (main_last),
  .pend_s    (pend_s),
  .pend_m    (pend_m)
);

// File: tb/test_pswl_divider.sv
module test_pswl_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        load_stb = 1'b0;
  logic [4:0]  sw_val = '0;
  logic [10:0] mn_val = '0;
  logic        fv;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pswl_divider i_pswl_divider (
    .clk_in      (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .load_stb    (load_stb),
    .swallow_val (sw_val),
    .main_val    (mn_val),
    .fv_pulse    (fv)
  );

  localparam int NV = 5;
  localparam logic [4:0]  V_S [NV] = '{5'd4, 5'd0, 5'd31, 5'd31, 5'd17};
  localparam logic [10:0] V_M [NV] = '{11'd314, 11'd32, 11'd32, 11'd2047, 11'd100};
  localparam int          V_N [NV] = '{10052, 1024, 1055, 65535, 3217};
  localparam bit          V_PER [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam string       V_TAG [NV] = '{"R2", "R5", "R5", "R8", "R2"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bench's own view of the ratio
  function automatic int ratio(input int s, input int m);
    return 32 * m + s;
  endfunction

  task automatic load_in_standby(input logic [4:0] s, input logic [10:0] m);
    @(negedge clk);
    run_en = 1'b0; load_stb = 1'b1; sw_val = s; mn_val = m;
    @(negedge clk);
    load_stb = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
  endtask

  // counts negedges from a starting value until fv is seen
  task automatic wait_pulse(input int start, input int limit, output int cyc);
    cyc = start;
    do begin
      @(negedge clk);
      cyc++;
    end while (!fv && cyc < limit);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    int exp_n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(fv == 1'b0, "R1 reset output", int'(fv), 0);
    run_en = 1'b1;
    rst_n  = 1'b1;
    wait_pulse(0, 1100, cyc);
    check(cyc == 1024, "R1 default ratio", cyc, 1024);

    // vector table
    for (int i = 0; i < NV; i++) begin
      exp_n = ratio(int'(V_S[i]), int'(V_M[i]));
      check(exp_n == V_N[i], {V_TAG[i], " table"}, exp_n, V_N[i]);
      load_in_standby(V_S[i], V_M[i]);
      wait_pulse(0, V_N[i] + 64, cyc);
      check(cyc == V_N[i], {V_TAG[i], " first pulse"}, cyc, V_N[i]);
      @(negedge clk);
      check(fv == 1'b0, "R4 single cycle", int'(fv), 0);
      if (V_PER[i]) begin
        wait_pulse(1, V_N[i] + 64, cyc);
        check(cyc == V_N[i], "R3 steady period", cyc, V_N[i]);
      end
    end

    // R6: standby mid-cycle restarts the count
    load_in_standby(5'd5, 11'd40);
    repeat (500) @(negedge clk);
    check(fv == 1'b0, "R6 no early pulse", int'(fv), 0);
    run_en = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (fv) seen++;
      end
      check(seen == 0, "R6 quiet in standby", seen, 0);
    end
    run_en = 1'b1;
    wait_pulse(0, 1400, cyc);
    check(cyc == 1285, "R6 restart ratio", cyc, 1285);

    // R7: load mid-cycle only affects the next cycle
    @(negedge clk);
    cyc = 1;
    repeat (299) begin
      @(negedge clk);
      cyc++;
    end
    load_stb = 1'b1; sw_val = 5'd1; mn_val = 11'd33;
    @(negedge clk);
    cyc++;
    load_stb = 1'b0;
    wait_pulse(cyc, 1400, cyc);
    check(cyc == 1285, "R7 current period kept", cyc, 1285);
    @(negedge clk);
    wait_pulse(1, 1400, cyc);
    check(cyc == 1057, "R7 next period new", cyc, 1057);

    $display("== %0d vectors applied, %0d miscompares ==", tests, fails);
    $finish;
  end
endmodule